// File: doc/BRIEF.md
# Edge White Mask and Error Line Concealment

This block sits after a line decoder. Decoded scan lines arrive as a stream of 16-pixel words. The block forces every pixel inside a programmable left margin and a programmable right margin to white. When the decoder reports that a line was bad, the block hides the damage. It emits either the last line that decoded cleanly or an all-white line in its place. A mode bit selects which. The margin mask also applies to the substituted line.

The error flag only becomes known with the last word of a line. For that reason the block takes in a whole line before it releases any of it. Internally it keeps two line banks. One bank collects the incoming line. The other holds the most recent good line.

A good line is released from the bank it was written into, and that bank then becomes the new reference line. An errored line never replaces the reference. The line length, in words, comes from a configuration input. The margins are given in single pixels.

Top module: `line_mask_conceal`

## Requirements
- R1: While reset is asserted, and right after it is released, `inReady` is 1 and `outValid` is 0.
- R2: No output word is offered while a line is being received. `outValid` rises in the cycle after the word carrying `inEol` is accepted, and the first offered word carries `outSol`.
- R3: Each released line has exactly `cfgLineWords` words. `outSol` is set on the first word and `outEol` on the last. After the last word is taken, `inReady` returns to 1 and `outValid` to 0.
- R4: Pixel value 0 is white and 1 is black. Bit 15 of a word is the leftmost pixel, so bit b of word k is pixel index k*16+15-b. With both margins at 0, a good line is output unchanged.
- R5: Every pixel whose index is below `cfgLeftMargin` is output as 0.
- R6: Every pixel whose index is at least `cfgLineWords*16 - cfgRightMargin` is output as 0.
- R7: When the two margins together cover the line, every word of the line is output as 0.
- R8: An errored line with `cfgSubstPrev`=1 is replaced by the most recent error-free line, masked with the current margins.
- R9: An errored line with `cfgSubstPrev`=0 is replaced by an all-white line.
- R10: Before any error-free line has been received, an errored line is output as white in either mode.
- R11: An errored line never becomes the reference line, whichever substitution mode was used for it.
- R12: While `outValid` is 1 and `outReady` is 0, the offered word and its framing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLineWords | input | 9 | Words per line, 1 to 304 |
| cfgLeftMargin | input | 13 | Left margin in pixels |
| cfgRightMargin | input | 13 | Right margin in pixels |
| cfgSubstPrev | input | 1 | 1: errored line becomes previous good line; 0: white line |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inData | input | 16 | Input pixels, bit 15 leftmost |
| inSol | input | 1 | First word of a line |
| inEol | input | 1 | Last word of a line |
| inErr | input | 1 | Line decode error, sampled with inEol |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream takes the word |
| outData | output | 16 | Masked output pixels |
| outSol | output | 1 | First output word of a line |
| outEol | output | 1 | Last output word of a line |

## Verification
The hardest case to reach from the ports is a reference line that must survive a run of errored lines in both substitution modes. A bug here shows only when a later substitution gives back the wrong line. The stimulus builds that history on purpose.

First it sends an errored line before any good one. Then it sends a good line, followed by errored lines that alternate between previous-line and white substitution. Each later substitution must return the same earlier good line. A second case is the full grid of left and right margin pairs, including pairs that overlap. The bench sweeps it over a three-word line with errored lines mixed in at fixed places.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  parameter int WORD_W    = 16;
  parameter int MAX_WORDS = 304;
  localparam int LOG_W  = $clog2(WORD_W);
  localparam int IDX_W  = $clog2(MAX_WORDS);
  localparam int LEN_W  = $clog2(MAX_WORDS + 1);
  localparam int PIX_W  = IDX_W + LOG_W;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrAddr;
    logic [IDX_W-1:0] rdIdx;
    logic             errLine;
    logic             commit;
  } ctlStrobes_t;
endpackage

// File: rtl/lmc_ctrl.sv
module lmc_ctrl
  import lmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] cfgLineWords,
  input  logic             inValid,
  input  logic             inSol,
  input  logic             inEol,
  input  logic             inErr,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSol,
  output logic             outEol,
  output ctlStrobes_t      ctl
);
  typedef enum logic {PH_FILL, PH_DRAIN} phase_t;

  phase_t           phase;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             errQ;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] wrAddr;
  logic             inAccept;
  logic             outTake;
  logic             lastOut;

  assign lastIdx  = IDX_W'(cfgLineWords - LEN_W'(1));
  assign inReady  = (phase == PH_FILL);
  assign outValid = (phase == PH_DRAIN);
  assign inAccept = inValid && inReady;
  assign outTake  = outValid && outReady;
  assign lastOut  = (rdIdx == lastIdx);
  assign wrAddr   = inSol ? '0 : wrIdx;
  assign outSol   = outValid && (rdIdx == '0);
  assign outEol   = outValid && lastOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FILL;
      wrIdx <= '0;
      rdIdx <= '0;
      errQ  <= 1'b0;
    end else begin
      case (phase)
        PH_FILL: if (inAccept) begin
          if (inEol) begin
            phase <= PH_DRAIN;
            rdIdx <= '0;
            errQ  <= inErr;
            wrIdx <= '0;
          end else if (wrAddr != IDX_W'(MAX_WORDS - 1)) begin
            wrIdx <= wrAddr + 1'b1;
          end else begin
            wrIdx <= wrAddr;
          end
        end
        PH_DRAIN: if (outTake) begin
          if (lastOut) phase <= PH_FILL;
          else         rdIdx <= rdIdx + 1'b1;
        end
        default: phase <= PH_FILL;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.wrEn    = inAccept;
    ctl.wrAddr  = wrAddr;
    ctl.rdIdx   = rdIdx;
    ctl.errLine = errQ;
    ctl.commit  = outTake && lastOut && !errQ;
  end

  AST_NO_OUT_WHILE_FILLING: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid)); // R2
  AST_DRAIN_AFTER_EOL: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && inEol |=> outValid && outSol); // R2
  AST_FILL_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && outEol |=> inReady && !outValid); // R3
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(rdIdx) && $stable(outSol)); // R12
endmodule

// File: rtl/lmc_datapath.sv
module lmc_datapath
  import lmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfgLineWords,
  input  logic [PIX_W-1:0]  cfgLeftMargin,
  input  logic [PIX_W-1:0]  cfgRightMargin,
  input  logic              cfgSubstPrev,
  input  logic [WORD_W-1:0] inData,
  input  logic              outValid,
  input  ctlStrobes_t       ctl,
  output logic [WORD_W-1:0] outData
);
  logic [WORD_W-1:0] lineMem [2][MAX_WORDS];
  logic              curBank;
  logic              prevValid;
  logic [WORD_W-1:0] srcWord;
  logic [WORD_W-1:0] keepMask;
  logic [PIX_W-1:0]  lineBits;

  assign lineBits = PIX_W'(32'(cfgLineWords) * WORD_W);

  always_ff @(posedge clk) begin
    if (ctl.wrEn) lineMem[curBank][ctl.wrAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curBank   <= 1'b0;
      prevValid <= 1'b0;
    end else if (ctl.commit) begin
      curBank   <= ~curBank;
      prevValid <= 1'b1;
    end
  end

  always_comb begin
    if (!ctl.errLine)                  srcWord = lineMem[curBank][ctl.rdIdx];
    else if (cfgSubstPrev && prevValid) srcWord = lineMem[~curBank][ctl.rdIdx];
    else                               srcWord = '0;
  end

  for (genvar b = 0; b < WORD_W; b++) begin : g_pix
    logic [PIX_W-1:0] pixIdx;
    logic             inLeft;
    logic             inRight;
    assign pixIdx  = {ctl.rdIdx, LOG_W'(WORD_W - 1 - b)};
    assign inLeft  = pixIdx < cfgLeftMargin;
    assign inRight = ({1'b0, pixIdx} + {1'b0, cfgRightMargin}) >= {1'b0, lineBits};
    assign keepMask[b] = !(inLeft || inRight);
  end

  assign outData = srcWord & keepMask;

  AST_WHITE_SUBST: assert property (@(posedge clk) disable iff (rst)
    outValid && ctl.errLine && !cfgSubstPrev |-> outData == '0); // R9
  AST_LEFT_WORD_WHITE: assert property (@(posedge clk) disable iff (rst)
    outValid && ctl.rdIdx == '0 && cfgLeftMargin >= PIX_W'(WORD_W) |-> outData == '0); // R5
  AST_OVERLAP_WHITE: assert property (@(posedge clk) disable iff (rst)
    outValid && ({1'b0, cfgLeftMargin} + {1'b0, cfgRightMargin} >= {1'b0, lineBits})
    |-> outData == '0); // R7
  AST_NO_COMMIT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    ctl.errLine |=> $stable(curBank)); // R11
endmodule

// File: rtl/line_mask_conceal.sv
module line_mask_conceal
  import lmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfgLineWords,
  input  logic [PIX_W-1:0]  cfgLeftMargin,
  input  logic [PIX_W-1:0]  cfgRightMargin,
  input  logic              cfgSubstPrev,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inSol,
  input  logic              inEol,
  input  logic              inErr,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic              outSol,
  output logic              outEol
);
  ctlStrobes_t ctl;

  lmc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cfgLineWords (cfgLineWords),
    .inValid      (inValid),
    .inSol        (inSol),
    .inEol        (inEol),
    .inErr        (inErr),
    .inReady      (inReady),
    .outValid     (outValid),
    .outReady     (outReady),
    .outSol       (outSol),
    .outEol       (outEol),
    .ctl          (ctl)
  );

  lmc_datapath u_dp (
    .clk            (clk),
    .rst            (rst),
    .cfgLineWords   (cfgLineWords),
    .cfgLeftMargin  (cfgLeftMargin),
    .cfgRightMargin (cfgRightMargin),
    .cfgSubstPrev   (cfgSubstPrev),
    .inData         (inData),
    .outValid       (outValid),
    .ctl            (ctl),
    .outData        (outData)
  );
endmodule

// File: tb/line_mask_conceal_tb.sv
module line_mask_conceal_tb;
  import lmc_pkg::*;
  localparam int NW   = 3;
  localparam int NPIX = NW * WORD_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LEN_W-1:0]  cfgLineWords = LEN_W'(NW);
  logic [PIX_W-1:0]  cfgLeftMargin = '0;
  logic [PIX_W-1:0]  cfgRightMargin = '0;
  logic              cfgSubstPrev = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [WORD_W-1:0] inData = '0;
  logic              inSol = 1'b0;
  logic              inEol = 1'b0;
  logic              inErr = 1'b0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [WORD_W-1:0] outData;
  logic              outSol;
  logic              outEol;

  int checks = 0;
  int fails  = 0;
  logic [WORD_W-1:0] prevLine [NW];
  bit prevOk = 1'b0;

  always #5 clk = ~clk;

  line_mask_conceal u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  function automatic logic [WORD_W-1:0] pat(int line, int k);
    int v = (line * 40503) + (k * 9973) + 23100;
    return WORD_W'(v ^ (v >> 5));
  endfunction

  function automatic logic [WORD_W-1:0] maskW(logic [WORD_W-1:0] w, int k, int l, int r);
    logic [WORD_W-1:0] m = w;
    for (int b = 0; b < WORD_W; b++) begin
      int p = k * WORD_W + (WORD_W - 1 - b);
      if (p < l || p >= NPIX - r) m[b] = 1'b0;
    end
    return m;
  endfunction

  // Sends one line and collects its output; starts and ends at a falling edge.
  task automatic runLine(int line, bit err, int l, int r, bit mode, string tag, bit stall);
    logic [WORD_W-1:0] data [NW];
    logic [WORD_W-1:0] src [NW];
    logic [WORD_W-1:0] held;
    cfgLeftMargin  = PIX_W'(l);
    cfgRightMargin = PIX_W'(r);
    cfgSubstPrev   = mode;
    for (int k = 0; k < NW; k++) begin
      data[k] = pat(line, k);
      if (!err)               src[k] = data[k];
      else if (mode && prevOk) src[k] = prevLine[k];
      else                    src[k] = '0;
    end
    for (int k = 0; k < NW; k++) begin
      inValid = 1'b1;
      inData  = data[k];
      inSol   = (k == 0);
      inEol   = (k == NW - 1);
      inErr   = err && (k == NW - 1);
      if (k == NW - 1) chk("R2 no output before eol", int'(outValid), 0);
      @(negedge clk);
    end
    inValid = 1'b0; inSol = 1'b0; inEol = 1'b0; inErr = 1'b0;
    chk("R2 output after eol", int'(outValid), 1);
    for (int k = 0; k < NW; k++) begin
      if (stall && k == 1) begin
        held = outData;
        outReady = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 valid held", int'(outValid), 1);
        chk("R12 data held", int'(outData), int'(held));
        outReady = 1'b1;
      end
      chk(tag, int'(outData), int'(maskW(src[k], k, l, r)));
      if (k == 0)      chk("R3 sol", int'(outSol), 1);
      if (k == NW - 1) chk("R3 eol", int'(outEol), 1);
      @(negedge clk);
    end
    chk("R3 back to input", int'({inReady, outValid}), 2);
    if (!err) begin
      for (int k = 0; k < NW; k++) prevLine[k] = data[k];
      prevOk = 1'b1;
    end
  endtask

  initial begin
    @(negedge clk);
    chk("R1 reset inReady", int'(inReady), 1);
    chk("R1 reset outValid", int'(outValid), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", int'({inReady, outValid}), 2);

    // R10: errors before any good line come out white in both modes
    runLine(1, 1'b1, 0, 0, 1'b1, "R10 prev mode", 1'b0);
    runLine(2, 1'b1, 0, 0, 1'b0, "R10 white mode", 1'b0);

    // R4: plain pass-through, with one stall for R12
    runLine(3, 1'b0, 0, 0, 1'b0, "R4", 1'b1);
    runLine(4, 1'b0, 0, 0, 1'b1, "R4", 1'b0);

    // Full margin sweep, errors mixed in
    for (int l = 0; l <= NPIX; l++) begin
      for (int r = 0; r <= NPIX; r++) begin
        int  line = 100 + l * (NPIX + 1) + r;
        bit  err  = (line % 7) == 3;
        bit  mode = line[3];
        string tag;
        if (err)                   tag = (mode && prevOk) ? "R8 sweep" : "R9 sweep";
        else if (l + r >= NPIX)    tag = "R7";
        else if (l == 0 && r == 0) tag = "R4";
        else                       tag = "R5/R6";
        runLine(line, err, l, r, mode, tag, 1'b0);
      end
    end

    // R11: errored lines do not replace the reference line
    runLine(9000, 1'b0, 0, 0, 1'b1, "R4", 1'b0);
    runLine(9001, 1'b1, 5, 7, 1'b1, "R8", 1'b0);
    runLine(9002, 1'b1, 0, 0, 1'b1, "R11 after prev subst", 1'b0);
    runLine(9003, 1'b1, 0, 0, 1'b0, "R9", 1'b1);
    runLine(9004, 1'b1, 3, 0, 1'b1, "R11 after white subst", 1'b0);
    runLine(9005, 1'b0, 17, 20, 1'b0, "R5/R6", 1'b0);
    runLine(9006, 1'b1, 0, 0, 1'b1, "R8 newest good", 1'b0);

    report();
    $finish;
  end
endmodule